// File: doc/BRIEF.md
# I2C Data Acquisition Slave Controller

This block is the digital front end of a small acquisition device with four analog inputs and one analog output, seen from an I2C master. It recognises its own 7-bit bus address and takes the direction of the transfer from the R/W bit. In a write transfer it loads a control register and a DAC code. In a read transfer it returns 8-bit conversion results. It also tracks which input channel the external successive-approximation sequencer converts next.

Reads are pipelined. Each acknowledge that asks for a byte starts a new conversion. The byte that is then shifted out is the result of the conversion before it. The analog parts and the open-drain pad are outside the block. The pad appears as a separate SDA input, a SDA output value and an output enable.

Top module: `daq_i2c_slave`

## Requirements
- R1: The slave answers the 7-bit address {4'b1001, addr_pins[2], addr_pins[1], addr_pins[0]}. It pulls SDA low during the ninth clock of the address byte. For any other address it does not drive SDA until the next START, and it ignores the bytes that follow.
- R2: Bit 0 of the address byte, the last bit sent, selects the transfer direction: 1 is a read and 0 is a write.
- R3: The first data byte of a write loads the control register, which is seen on ctrl_o. Bits 7 and 3 of ctrl_o are always 0, whatever value was written.
- R4: Every write data byte after the first loads dac_data, and the slave acknowledges each of them. dac_data keeps its value until the next such byte.
- R5: aout_en equals control bit 6.
- R6: Control bits 5:4 select the input mode. In mode 0 the highest channel is 3, in modes 1 and 2 it is 2, and in mode 3 it is 1. Bit 2 enables auto-increment. Bits 1:0 hold the channel. A written channel code above the highest channel of its mode is stored as that highest channel.
- R7: With auto-increment on, the channel advances by one after each conversion start and wraps from the highest channel to 0. With auto-increment off, the channel does not change.
- R8: After reset, ctrl_o, dac_data and aout_en are 0, SDA is released, and the first byte read is 0x80.
- R9: conv_start is a one-cycle pulse. It fires when SCL falls at the end of the acknowledge of a matching read address, and conv_channel gives the channel in use at that moment.
- R10: Each byte read is the adc_data value latched at the most recent adc_done before that byte's conversion start. A master ACK of a read byte starts the next conversion.
- R11: A master NACK ends the read burst without a conversion start, and the slave leaves SDA released afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_o | output | 1 | Value driven onto SDA when enabled (always 0) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_pins | input | 3 | Strap bits forming the low three address bits |
| adc_done | input | 1 | Sequencer signals that a result is ready |
| adc_data | input | 8 | Result from the sequencer |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| conv_channel | output | 2 | Channel to convert, valid with conv_start |
| ctrl_o | output | 8 | Current control register, channel field included |
| dac_data | output | 8 | Code for the output converter |
| aout_en | output | 1 | Analog output enable |

## Verification
SCL and SDA pass through a two-stage synchronizer and an edge register, so every bus-driven result appears about three system clocks after the SCL edge that causes it. The bench keeps each bus phase eight clocks long and samples outputs on falling clock edges. A register write is checked only after the acknowledge bit completes. An ACK is read in the middle of the high phase of the ninth clock. conv_start is caught on the falling clock edge of the cycle in which the pulse is high, and a model sequencer answers with adc_done five cycles later, well before the result can be shifted out.

// File: rtl/daq_pkg.sv
package daq_pkg;

  localparam int BYTE_W = 8;
  localparam int CH_W   = 2;
  localparam logic [3:0] ADDR_PREFIX = 4'b1001;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WR,
    S_WR_ACK,
    S_RD,
    S_RD_ACK
  } bus_state_t;

  // highest usable channel for each input mode
  function automatic logic [CH_W-1:0] top_chan(input logic [1:0] mode);
    case (mode)
      2'd0:    top_chan = 2'd3;
      2'd1:    top_chan = 2'd2;
      2'd2:    top_chan = 2'd2;
      default: top_chan = 2'd1;
    endcase
  endfunction

  function automatic logic [CH_W-1:0] clamp_chan(input logic [CH_W-1:0] code,
                                                 input logic [1:0] mode);
    clamp_chan = (code > top_chan(mode)) ? top_chan(mode) : code;
  endfunction

  function automatic logic [CH_W-1:0] next_chan(input logic [CH_W-1:0] ch,
                                                input logic [1:0] mode);
    next_chan = (ch >= top_chan(mode)) ? '0 : ch + 1'b1;
  endfunction

  function automatic logic addr_match(input logic [6:0] addr7,
                                      input logic [2:0] pins);
    addr_match = (addr7 == {ADDR_PREFIX, pins});
  endfunction

endpackage

// File: rtl/daq_bus_sense.sv
module daq_bus_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_sync, sda_sync;
  logic          scl_q, sda_q;
  logic          scl_lvl;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= scl_i;
          sda_sync <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= {scl_sync[LAST-1:0], scl_i};
          sda_sync <= {sda_sync[LAST-1:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_sync[LAST];
  assign sda_lvl = sda_sync[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/daq_chan_ctl.sv
module daq_chan_ctl
  import daq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              conv_fire,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [CH_W-1:0]   chan,
  output logic              aout_en
);
  logic [1:0] mode;
  logic       ainc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      ainc    <= 1'b0;
      aout_en <= 1'b0;
      chan    <= '0;
    end else if (ctrl_wr) begin
      mode    <= wr_byte[5:4];
      ainc    <= wr_byte[2];
      aout_en <= wr_byte[6];
      chan    <= clamp_chan(wr_byte[1:0], wr_byte[5:4]);
    end else if (conv_fire && ainc) begin
      chan    <= next_chan(chan, mode);
    end
  end

  assign ctrl_o = {1'b0, aout_en, mode, 1'b0, ainc, chan};

endmodule

// File: rtl/daq_result_pipe.sv
module daq_result_pipe
  import daq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_VALUE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_done,
  input  logic [BYTE_W-1:0] adc_data,
  output logic [BYTE_W-1:0] result
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result <= RESET_VALUE;
    else if (adc_done) result <= adc_data;
  end
endmodule

// File: rtl/daq_i2c_slave.sv
module daq_i2c_slave
  import daq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] FIRST_READ = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic [2:0]        addr_pins,
  input  logic              adc_done,
  input  logic [BYTE_W-1:0] adc_data,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_channel,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] dac_data,
  output logic              aout_en
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_state_t        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] rx_shift, tx_shift, result;
  logic              oe_q, first_wr, mst_ack;

  // named bus events
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic byte_end, addr_hit, ctrl_wr, dac_wr, conv_fire;

  daq_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  daq_chan_ctl u_chan (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_byte(rx_shift),
    .conv_fire(conv_fire), .ctrl_o(ctrl_o), .chan(conv_channel),
    .aout_en(aout_en)
  );

  daq_result_pipe #(.RESET_VALUE(FIRST_READ)) u_result (
    .clk(clk), .rst_n(rst_n), .adc_done(adc_done), .adc_data(adc_data),
    .result(result)
  );

  assign byte_end  = scl_fall && (bitcnt == FULL);
  assign addr_hit  = (state == S_ADDR) && byte_end && addr_match(rx_shift[7:1], addr_pins);
  assign ctrl_wr   = (state == S_WR) && byte_end && first_wr && !start_det && !stop_det;
  assign dac_wr    = (state == S_WR) && byte_end && !first_wr && !start_det && !stop_det;
  assign conv_fire = scl_fall && !start_det && !stop_det &&
                     (((state == S_ADDR_ACK) && rx_shift[0]) ||
                      ((state == S_RD_ACK) && mst_ack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      rx_shift <= '0;
      tx_shift <= '0;
      oe_q     <= 1'b0;
      first_wr <= 1'b0;
      mst_ack  <= 1'b0;
    end else if (start_det) begin
      state  <= S_ADDR;
      bitcnt <= '0;
      oe_q   <= 1'b0;
    end else if (stop_det) begin
      state <= S_IDLE;
      oe_q  <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_WR: begin
          if (scl_rise) begin
            rx_shift <= {rx_shift[BYTE_W-2:0], sda_lvl};
            bitcnt   <= bitcnt + 1'b1;
          end else if (byte_end) begin
            if (state == S_WR) begin
              state    <= S_WR_ACK;
              oe_q     <= 1'b1;
              first_wr <= 1'b0;
            end else if (addr_hit) begin
              state <= S_ADDR_ACK;
              oe_q  <= 1'b1;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rx_shift[0]) begin
              state    <= S_RD;
              tx_shift <= result;
              oe_q     <= ~result[BYTE_W-1];
            end else begin
              state    <= S_WR;
              oe_q     <= 1'b0;
              first_wr <= 1'b1;
            end
          end
        end
        S_WR_ACK: begin
          if (scl_fall) begin
            state  <= S_WR;
            oe_q   <= 1'b0;
            bitcnt <= '0;
          end
        end
        S_RD: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            state <= S_RD_ACK;
            oe_q  <= 1'b0;
          end else if (scl_fall) begin
            tx_shift <= {tx_shift[BYTE_W-2:0], 1'b0};
            oe_q     <= ~tx_shift[BYTE_W-2];
          end
        end
        S_RD_ACK: begin
          if (scl_rise) begin
            mst_ack <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mst_ack) begin
              state    <= S_RD;
              bitcnt   <= '0;
              tx_shift <= result;
              oe_q     <= ~result[BYTE_W-1];
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dac_data <= '0;
    else if (dac_wr) dac_data <= rx_shift;
  end

  assign conv_start = conv_fire;
  assign sda_oe     = oe_q;
  assign sda_o      = 1'b0;

endmodule

// File: rtl/daq_i2c_slave_chk.sv
module daq_i2c_slave_chk
  import daq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  ctrl_o,
  input logic [7:0]  dac_data,
  input logic        conv_start,
  input logic        sda_oe,
  input logic        scl_fall,
  input logic        start_det,
  input logic        dac_wr
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[7] == 1'b0) && (ctrl_o[3] == 1'b0)); // R3

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr |=> $stable(dac_data)); // R4

  AST_CHAN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[1:0] <= top_chan(ctrl_o[5:4])); // R6

  AST_AINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && ctrl_o[2]) |=>
      (ctrl_o[1:0] == next_chan($past(ctrl_o[1:0]), $past(ctrl_o[5:4])))); // R7

  AST_CHAN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !ctrl_o[2]) |=> $stable(ctrl_o[1:0])); // R7

  AST_CONV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R9

  AST_CONV_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> scl_fall); // R9

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe); // R1
endmodule

bind daq_i2c_slave daq_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_o(ctrl_o), .dac_data(dac_data),
  .conv_start(conv_start), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_det(start_det), .dac_wr(dac_wr)
);

// File: tb/daq_i2c_slave_test.sv
module daq_i2c_slave_test;
  localparam int Q = 8;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] AW = {4'b1001, PINS, 1'b0};
  localparam logic [7:0] AR = {4'b1001, PINS, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic adc_done = 1'b0;
  logic [7:0] adc_data = 8'h00;
  logic sda_o, sda_oe, conv_start, aout_en;
  logic [1:0] conv_channel;
  logic [7:0] ctrl_o, dac_data;
  wire sda_line = sda_oe ? (sda_o & sda_m) : sda_m;

  int checks = 0, fails = 0, oe_cnt = 0, conv_n = 0, sar_wait = 0;
  logic prev_conv = 1'b0, done = 1'b0;
  logic [7:0] model_result = 8'h80, pending = 8'h00;
  logic [7:0] exp_q[$];
  logic [1:0] chan_q[$];

  always #4 clk = ~clk;

  daq_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .addr_pins(PINS),
    .adc_done(adc_done), .adc_data(adc_data), .conv_start(conv_start),
    .conv_channel(conv_channel), .ctrl_o(ctrl_o), .dac_data(dac_data),
    .aout_en(aout_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model sequencer plus predictor: at each conversion start the byte to be
  // shifted out is the previous result
  always @(negedge clk) begin
    adc_done <= 1'b0;
    if (sda_oe) oe_cnt <= oe_cnt + 1;
    prev_conv <= conv_start;
    if (conv_start) begin
      check("R9 single-cycle pulse", {31'd0, prev_conv}, 32'd0);
      check("R9 start while SCL low", {31'd0, scl_m}, 32'd0);
      exp_q.push_back(model_result);
      if (chan_q.size() == 0) begin
        check("R11 unexpected conversion", 32'd1, 32'd0);
      end else begin
        check("R9 conv_channel", {30'd0, conv_channel}, {30'd0, chan_q.pop_front()});
      end
      pending  <= 8'h31 + 8'(conv_n) * 8'h13 + {6'd0, conv_channel};
      conv_n   <= conv_n + 1;
      sar_wait <= 5;
    end else if (sar_wait > 0) begin
      sar_wait <= sar_wait - 1;
      if (sar_wait == 1) begin
        adc_done     <= 1'b1;
        adc_data     <= pending;
        model_result <= pending;
      end
    end
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = sda_line; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic write_byte(input logic [7:0] d, input logic exp_ack, input string tag);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    check(tag, {31'd0, ~b}, {31'd0, exp_ack});
  endtask

  // monitor side: pops the predicted byte and compares
  task automatic read_byte(input logic ack, input string tag);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~ack);
    if (exp_q.size() == 0) check({tag, " no prediction"}, 32'd1, 32'd0);
    else check(tag, {24'd0, d}, {24'd0, exp_q.pop_front()});
  endtask

  initial begin
    int oe_before;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 ctrl reset", {24'd0, ctrl_o}, 32'h0);
    check("R8 dac reset", {24'd0, dac_data}, 32'h0);
    check("R8 aout_en reset", {31'd0, aout_en}, 32'h0);
    check("R8 sda released", {31'd0, sda_oe}, 32'h0);

    // foreign address: never driven, data ignored
    oe_before = oe_cnt;
    i2c_start();
    write_byte({4'b1001, 3'b000, 1'b0}, 1'b0, "R1 foreign address nack");
    write_byte(8'h3C, 1'b0, "R1 foreign data nack");
    i2c_stop();
    check("R1 SDA never driven", oe_cnt - oe_before, 32'd0);
    check("R1 ctrl untouched", {24'd0, ctrl_o}, 32'h0);

    // write: control with reserved bits set, then two DAC bytes
    i2c_start();
    write_byte(AW, 1'b1, "R1 own address ack");
    write_byte(8'hCC, 1'b1, "R3 control ack");
    check("R3 reserved bits cleared", {24'd0, ctrl_o}, 32'h44);
    check("R5 aout_en set", {31'd0, aout_en}, 32'd1);
    write_byte(8'h5A, 1'b1, "R4 dac ack 1");
    check("R4 dac first", {24'd0, dac_data}, 32'h5A);
    write_byte(8'hA7, 1'b1, "R4 dac ack 2");
    check("R4 dac second", {24'd0, dac_data}, 32'hA7);
    check("R4 ctrl unchanged by dac", {24'd0, ctrl_o}, 32'h44);
    i2c_stop();

    // read burst: ACK, ACK, NACK -> conversions on ch 0,1,2
    chan_q.push_back(2'd0); chan_q.push_back(2'd1); chan_q.push_back(2'd2);
    i2c_start();
    write_byte(AR, 1'b1, "R2 read address ack");
    check("R8 first read predicted 0x80", {24'd0, exp_q[0]}, 32'h80);
    read_byte(1'b1, "R8 first byte");
    read_byte(1'b1, "R10 byte 2");
    read_byte(1'b0, "R10 byte 3");
    repeat (4) @(negedge clk);
    check("R11 released after nack", {31'd0, sda_oe}, 32'd0);
    i2c_stop();
    check("R7 channel advanced", {30'd0, ctrl_o[1:0]}, 32'd3);

    // wrap from 3 to 0
    chan_q.push_back(2'd3); chan_q.push_back(2'd0);
    i2c_start();
    write_byte(AR, 1'b1, "R2 read address ack 2");
    read_byte(1'b1, "R10 burst2 byte1");
    read_byte(1'b0, "R10 burst2 byte2");
    i2c_stop();
    check("R7 wrap channel", {30'd0, ctrl_o[1:0]}, 32'd1);

    // mode 1, code 3 clamps to 2, auto-increment wraps to 0
    i2c_start();
    write_byte(AW, 1'b1, "R2 write address ack");
    write_byte(8'h17, 1'b1, "R6 control ack");
    i2c_stop();
    check("R6 clamp mode1", {24'd0, ctrl_o}, 32'h16);
    check("R5 aout_en cleared", {31'd0, aout_en}, 32'd0);
    chan_q.push_back(2'd2);
    i2c_start();
    write_byte(AR, 1'b1, "R2 read address ack 3");
    read_byte(1'b0, "R10 burst3 byte1");
    i2c_stop();
    check("R6 clamped then wrapped", {24'd0, ctrl_o}, 32'h14);

    // mode 3, code 3 clamps to 1, no auto-increment
    i2c_start();
    write_byte(AW, 1'b1, "R2 write address ack 2");
    write_byte(8'h33, 1'b1, "R6 control ack 2");
    i2c_stop();
    check("R6 clamp mode3", {24'd0, ctrl_o}, 32'h31);
    chan_q.push_back(2'd1); chan_q.push_back(2'd1);
    i2c_start();
    write_byte(AR, 1'b1, "R2 read address ack 4");
    read_byte(1'b1, "R10 burst4 byte1");
    read_byte(1'b0, "R10 burst4 byte2");
    i2c_stop();
    check("R7 channel fixed", {24'd0, ctrl_o}, 32'h31);

    // mode 2 clamp and auto-increment from the top channel
    i2c_start();
    write_byte(AW, 1'b1, "R2 write address ack 3");
    write_byte(8'h27, 1'b1, "R6 control ack 3");
    i2c_stop();
    check("R6 clamp mode2", {24'd0, ctrl_o}, 32'h26);
    chan_q.push_back(2'd2);
    i2c_start();
    write_byte(AR, 1'b1, "R2 read address ack 5");
    read_byte(1'b0, "R10 burst5 byte1");
    i2c_stop();
    check("R7 mode2 wrap", {24'd0, ctrl_o}, 32'h24);

    repeat (20) @(negedge clk);
    check("R11 no extra conversions", chan_q.size(), 32'd0);
    check("R10 all bytes consumed", exp_q.size(), 32'd0);
    check("R4 dac held", {24'd0, dac_data}, 32'hA7);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule